// File: doc/BRIEF.md
# Serial Addressed Control Register Bank

This block takes configuration words over a three-wire serial port (serial clock, serial data, load strobe) and keeps them in a bank of three 14-bit control registers. While the load strobe is high, one bit is taken on each rising edge of the serial clock. When the strobe falls, the most recent 16 bits form one frame. The upper 14 bits of the frame are the register contents and the lower 2 bits are the register address. The frame is then written into the register at that address. All serial inputs are resynchronised to the system clock, so the write takes effect a few system cycles after the strobe falls.

Two of the registers hold configuration values for downstream circuits. The third is a test-mode register. Its upper eight data bits are reserved and are always stored as zero. Its low six bits are split into a 3-bit digital test selector and a 3-bit analog test selector. The block raises a ready status once both configuration registers have been written. It keeps sticky flags for short frames, for reserved bits written as 1, and for a chip-enable request that arrives before the configuration is complete.

Top module: `ctl_bank`

## Requirements
- R1: After a synchronous reset, all three registers, both test selectors, the ready status and all three flags are zero.
- R2: Each frame is sent data MSB first (DB13 down to DB0), then ADR1, then ADR0. Frame bit 15..2 holds the data and frame bit 1..0 holds the address. A bit is taken on a rising serial clock edge while the load strobe is high.
- R3: A write happens only on a falling edge of the load strobe. If more than 16 bits were sent in the window, only the last 16 are used.
- R4: Address 0 selects configuration register A, address 1 selects configuration register B and address 2 selects the test register. A frame with address 3 changes no register.
- R5: If fewer than 16 bits were sent in a load window, no register is written and `short_err` is set. It stays set until reset.
- R6: A write to the test register stores data bits 13..6 as zero. If any of those bits was 1 in the frame, `rsv_warn` is set and stays set until reset.
- R7: `dig_test_mode` shows test register bits 5..3 and `ana_test_mode` shows bits 2..0.
- R8: `cfg_ready` goes high once both configuration registers have been written since reset, and stays high after that.
- R9: If `en_req` is high while `cfg_ready` is low, `seq_err` is set and stays set until reset.
- R10: Serial clock edges while the load strobe is low shift nothing. The bit count starts again at each rising edge of the load strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock, asynchronous to clk |
| ser_data | input | 1 | Serial data |
| ser_load | input | 1 | Load strobe; its falling edge commits the frame |
| en_req | input | 1 | Chip-enable request, synchronous to clk |
| cfg_a_q | output | 14 | Configuration register A (address 0) |
| cfg_b_q | output | 14 | Configuration register B (address 1) |
| test_q | output | 14 | Test-mode register (address 2) |
| dig_test_mode | output | 3 | Digital test selector |
| ana_test_mode | output | 3 | Analog test selector |
| cfg_ready | output | 1 | Both configuration registers written |
| short_err | output | 1 | Sticky short-frame flag |
| seq_err | output | 1 | Sticky enable-before-configuration flag |
| rsv_warn | output | 1 | Sticky reserved-bit flag |

## Verification
A bit counter or shift register that goes wrong stays hidden until the next falling edge of the load strobe. At that point it shows up within three system cycles, either as the wrong register changing, a wrong value being stored, or a wrong `short_err`. A wrong write flag shows on `cfg_ready` in the cycle right after the commit. Because every output is compared with a reference model on every cycle, a wrong internal state is reported at the first frame boundary that exposes it, not only at the end of the run.

// File: rtl/ctl_bank_pkg.sv
package ctl_bank_pkg;

    localparam int DATA_W    = 14;
    localparam int ADDR_W    = 2;
    localparam int FRAME_W   = DATA_W + ADDR_W;
    localparam int NUM_REGS  = 3;
    localparam int TEST_ADDR = 2;
    localparam int RSV_LSB   = 6;
    localparam int TM_W      = 3;
    localparam int SYNC_LEN  = 2;

    typedef logic [DATA_W-1:0] word_t;

    // Data occupies the high part because it is shifted in first.
    typedef struct packed {
        word_t             data;
        logic [ADDR_W-1:0] addr;
    } frame_t;

    function automatic word_t scrub_rsv(word_t w);
        word_t keep;
        keep = '0;
        keep[RSV_LSB-1:0] = '1;
        return w & keep;
    endfunction

    function automatic logic rsv_hit(word_t w);
        return |(w >> RSV_LSB);
    endfunction

endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_d
);
    logic [W-1:0] pipe [STAGES+1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i <= STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i <= STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q   = pipe[STAGES-1];
    assign q_d = pipe[STAGES];
endmodule

// File: rtl/ctl_frame_shift.sv
module ctl_frame_shift #(
    parameter int FRAME_W = 16,
    localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               win_open,
    input  logic               shift_en,
    input  logic               bit_in,
    output logic [FRAME_W-1:0] frame,
    output logic               full
);
    logic [CNT_W-1:0] cnt;

    assign full = (cnt == CNT_W'(FRAME_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            frame <= '0;
            cnt   <= '0;
        end else if (win_open) begin
            cnt <= '0;
        end else if (shift_en) begin
            frame <= {frame[FRAME_W-2:0], bit_in};
            if (!full) cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ctl_reg_file.sv
module ctl_reg_file
    import ctl_bank_pkg::*;
#(
    parameter int N_REGS = NUM_REGS,
    parameter int T_ADDR = TEST_ADDR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  frame_t            frm,
    output word_t             regs [N_REGS],
    output logic [N_REGS-1:0] written,
    output logic              rsv_flag
);
    for (genvar g = 0; g < N_REGS; g++) begin : g_reg
        logic hit;
        assign hit = commit && (frm.addr == ADDR_W'(g));
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g]    <= '0;
                written[g] <= 1'b0;
            end else if (hit) begin
                regs[g]    <= (g == T_ADDR) ? scrub_rsv(frm.data) : frm.data;
                written[g] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rsv_flag <= 1'b0;
        else if (commit && frm.addr == ADDR_W'(T_ADDR) && rsv_hit(frm.data))
            rsv_flag <= 1'b1;
    end
endmodule

// File: rtl/ctl_bank.sv
module ctl_bank
    import ctl_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_load,
    input  logic              en_req,
    output logic [DATA_W-1:0] cfg_a_q,
    output logic [DATA_W-1:0] cfg_b_q,
    output logic [DATA_W-1:0] test_q,
    output logic [TM_W-1:0]   dig_test_mode,
    output logic [TM_W-1:0]   ana_test_mode,
    output logic              cfg_ready,
    output logic              short_err,
    output logic              seq_err,
    output logic              rsv_warn
);
    logic [2:0] s_q, s_qd;
    logic       sclk_rise, load_lvl, load_rise, load_fall;
    logic [FRAME_W-1:0] frame_bits;
    logic       frame_full;
    word_t      regs [NUM_REGS];
    logic [NUM_REGS-1:0] written;

    ctl_sync #(.W(3), .STAGES(SYNC_LEN)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ser_data, ser_load, ser_clk}),
        .q   (s_q),
        .q_d (s_qd)
    );

    assign sclk_rise = s_q[0] & ~s_qd[0];
    assign load_lvl  = s_q[1];
    assign load_rise = s_q[1] & ~s_qd[1];
    assign load_fall = ~s_q[1] & s_qd[1];

    ctl_frame_shift #(.FRAME_W(FRAME_W)) i_shift (
        .clk      (clk),
        .rst      (rst),
        .win_open (load_rise),
        .shift_en (sclk_rise & load_lvl),
        .bit_in   (s_q[2]),
        .frame    (frame_bits),
        .full     (frame_full)
    );

    ctl_reg_file #(.N_REGS(NUM_REGS), .T_ADDR(TEST_ADDR)) i_regs (
        .clk      (clk),
        .rst      (rst),
        .commit   (load_fall & frame_full),
        .frm      (frame_t'(frame_bits)),
        .regs     (regs),
        .written  (written),
        .rsv_flag (rsv_warn)
    );

    assign cfg_a_q       = regs[0];
    assign cfg_b_q       = regs[1];
    assign test_q        = regs[TEST_ADDR];
    assign dig_test_mode = regs[TEST_ADDR][2*TM_W-1:TM_W];
    assign ana_test_mode = regs[TEST_ADDR][TM_W-1:0];
    assign cfg_ready     = written[0] & written[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            short_err <= 1'b0;
            seq_err   <= 1'b0;
        end else begin
            if (load_fall && !frame_full) short_err <= 1'b1;
            if (en_req && !cfg_ready)     seq_err   <= 1'b1;
        end
    end
endmodule

// File: rtl/ctl_bank_chk.sv
module ctl_bank_chk
    import ctl_bank_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              load_fall,
    input logic              frame_full,
    input logic              en_req,
    input logic [DATA_W-1:0] cfg_a_q,
    input logic [DATA_W-1:0] cfg_b_q,
    input logic [DATA_W-1:0] test_q,
    input logic              cfg_ready,
    input logic              short_err,
    input logic              seq_err,
    input logic              rsv_warn
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg_a_q == '0 && cfg_b_q == '0 && test_q == '0 &&
                        !cfg_ready && !short_err && !seq_err && !rsv_warn));

    // R3
    hold_no_commit_chk: assert property (@(posedge clk) disable iff (rst)
        !(load_fall && frame_full) |=> ($stable(cfg_a_q) && $stable(cfg_b_q) && $stable(test_q)));

    // R5
    short_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (load_fall && !frame_full) |=> short_err);

    // R5
    short_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        short_err |=> short_err);

    // R6
    rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
        test_q[DATA_W-1:RSV_LSB] == '0);

    // R6
    rsv_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        rsv_warn |=> rsv_warn);

    // R8
    ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_ready |=> cfg_ready);

    // R9
    seq_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (en_req && !cfg_ready) |=> seq_err);
endmodule

bind ctl_bank ctl_bank_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .load_fall  (load_fall),
    .frame_full (frame_full),
    .en_req     (en_req),
    .cfg_a_q    (cfg_a_q),
    .cfg_b_q    (cfg_b_q),
    .test_q     (test_q),
    .cfg_ready  (cfg_ready),
    .short_err  (short_err),
    .seq_err    (seq_err),
    .rsv_warn   (rsv_warn)
);

// File: tb/test_ctl_bank.sv
`timescale 1ns/1ps
module test_ctl_bank;
    logic clk = 1'b0;
    logic rst, ser_clk, ser_data, ser_load, en_req;
    logic [13:0] cfg_a_q, cfg_b_q, test_q;
    logic [2:0]  dig_test_mode, ana_test_mode;
    logic cfg_ready, short_err, seq_err, rsv_warn;

    always #2 clk = ~clk;

    ctl_bank i_ctl_bank (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_load(ser_load), .en_req(en_req),
        .cfg_a_q(cfg_a_q), .cfg_b_q(cfg_b_q), .test_q(test_q),
        .dig_test_mode(dig_test_mode), .ana_test_mode(ana_test_mode),
        .cfg_ready(cfg_ready), .short_err(short_err), .seq_err(seq_err),
        .rsv_warn(rsv_warn)
    );

    int vectors = 0;
    int misses  = 0;

    // stimulus values applied at the next step
    logic b_rst = 1'b1, b_clk = 1'b0, b_dat = 1'b0, b_ld = 1'b0, b_en = 1'b0;

    // reference model
    logic [3:0]  hist [$];
    logic [15:0] m_sh;
    int          m_cnt;
    logic [13:0] m_reg [3];
    logic [2:0]  m_w;
    logic        m_short, m_seq, m_warn;

    task automatic cmp(string tag, string name, int act, int exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, name, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        hist = {4'd0, 4'd0, 4'd0, 4'd0};
        m_sh = '0; m_cnt = 0; m_w = '0;
        for (int i = 0; i < 3; i++) m_reg[i] = '0;
        m_short = 0; m_seq = 0; m_warn = 0;
    endtask

    // hist entries: {en, data, load, sclk}; hist[k] = input k cycles ago
    task automatic model_step();
        logic [3:0] a, b;
        logic ready_old;
        logic [13:0] d;
        int ad;
        a = hist[2]; b = hist[3];
        ready_old = m_w[0] & m_w[1];
        if (hist[0][3] && !ready_old) m_seq = 1;
        if (!a[1] && b[1]) begin
            if (m_cnt >= 16) begin
                ad = int'(m_sh[1:0]);
                d  = m_sh[15:2];
                if (ad < 3) begin
                    if (ad == 2) begin
                        if (d[13:6] != 0) m_warn = 1;
                        d = d & 14'h003F;
                    end
                    m_reg[ad] = d;
                    m_w[ad] = 1;
                end
            end else begin
                m_short = 1;
            end
        end
        if (a[1] && !b[1]) m_cnt = 0;
        else if (a[0] && !b[0] && a[1]) begin
            m_sh = {m_sh[14:0], a[2]};
            if (m_cnt < 16) m_cnt++;
        end
    endtask

    task automatic compare_all();
        cmp("R3", "cfg_a_q", int'(cfg_a_q), int'(m_reg[0]));
        cmp("R3", "cfg_b_q", int'(cfg_b_q), int'(m_reg[1]));
        cmp("R6", "test_q", int'(test_q), int'(m_reg[2]));
        cmp("R7", "dig_test_mode", int'(dig_test_mode), int'(m_reg[2][5:3]));
        cmp("R7", "ana_test_mode", int'(ana_test_mode), int'(m_reg[2][2:0]));
        cmp("R8", "cfg_ready", int'(cfg_ready), int'(m_w[0] & m_w[1]));
        cmp("R5", "short_err", int'(short_err), int'(m_short));
        cmp("R9", "seq_err", int'(seq_err), int'(m_seq));
        cmp("R6", "rsv_warn", int'(rsv_warn), int'(m_warn));
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_all();
            rst = b_rst; ser_clk = b_clk; ser_data = b_dat; ser_load = b_ld; en_req = b_en;
            if (b_rst) model_reset();
            else begin
                hist.push_front({b_en, b_dat, b_ld, b_clk});
                void'(hist.pop_back());
                model_step();
            end
        end
    endtask

    task automatic pulse_bit(logic v);
        b_dat = v; b_clk = 0; step(3);
        b_clk = 1; step(3);
        b_clk = 0;
    endtask

    task automatic send(logic [31:0] v, int n);
        b_ld = 1; step(3);
        for (int i = n - 1; i >= 0; i--) pulse_bit(v[i]);
        step(2);
        b_ld = 0; step(8);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        misses++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        rst = 1; ser_clk = 0; ser_data = 0; ser_load = 0; en_req = 0;
        model_reset();
        step(4);
        b_rst = 0; step(3);
        // R1: everything clear after reset
        cmp("R1", "cfg_a_q", int'(cfg_a_q), 0);
        cmp("R1", "test_q", int'(test_q), 0);
        cmp("R1", "flags", int'({cfg_ready, short_err, seq_err, rsv_warn}), 0);

        // R9: enable request before configuration
        b_en = 1; step(1); b_en = 0; step(2);
        cmp("R9", "seq_err", int'(seq_err), 1);

        // R2: data MSB first, address last
        send(32'h6970, 16);
        cmp("R2", "cfg_a_q", int'(cfg_a_q), 'h1A5C);
        cmp("R8", "cfg_ready early", int'(cfg_ready), 0);
        send(32'h3C3D, 16);
        cmp("R4", "cfg_b_q", int'(cfg_b_q), 'h0F0F);
        cmp("R8", "cfg_ready", int'(cfg_ready), 1);

        // R7: test selectors
        send(32'h00AE, 16);
        cmp("R7", "dig_test_mode", int'(dig_test_mode), 5);
        cmp("R7", "ana_test_mode", int'(ana_test_mode), 3);
        cmp("R6", "rsv_warn clean", int'(rsv_warn), 0);

        // R4: address 3 is ignored
        send(32'hFFFF, 16);
        cmp("R4", "cfg_a_q", int'(cfg_a_q), 'h1A5C);
        cmp("R4", "cfg_b_q", int'(cfg_b_q), 'h0F0F);
        cmp("R4", "test_q", int'(test_q), 'h002B);

        // R6: reserved bits scrubbed
        send(32'hFF1A, 16);
        cmp("R6", "test_q", int'(test_q), 'h0006);
        cmp("R6", "rsv_warn", int'(rsv_warn), 1);

        // R3: long frame keeps last 16 bits
        send(32'hF048D, 20);
        cmp("R3", "cfg_b_q", int'(cfg_b_q), 'h0123);

        // R10: stray edges outside the window do not count
        for (int i = 0; i < 4; i++) pulse_bit(1'b1);
        step(4);
        send(32'h001, 12);
        cmp("R10", "cfg_b_q", int'(cfg_b_q), 'h0123);
        cmp("R10", "short_err", int'(short_err), 1);

        // R5: 15-bit frame is dropped
        send(32'h7FFC, 15);
        cmp("R5", "cfg_a_q", int'(cfg_a_q), 'h1A5C);
        cmp("R5", "short_err", int'(short_err), 1);

        step(4);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule